// File: doc/BRIEF.md
# Programmable Bus Cycle Timing Generator

This block runs one external bus cycle per accepted request. Four signal groups each take their place in the cycle from register values: the chip select, the read strobe, the write strobe and the address latch enable. Every group has an offset and a width, and the chip select also has a recovery time. A register value v always lasts v+1 clocks. The chip select alone decides how long the cycle is: offset, then width, then recovery. The strobes and the latch enable are placed inside that span. Each is measured from the start of the cycle.

A request gives the direction, an I/O-or-memory flag, a chip-select index, a flag that marks the target as an internal peripheral, and the echo-mode setting. A cycle to an internal peripheral runs its full timing but drives the pins only when echo is set. An external cycle always drives the pins. The timing inputs are captured when a request is accepted. A consistency check is made then and its result is shown on `cfg_err` until the next request is accepted.

Top module: `bus_cycle_timer`

## Requirements
- R1: During reset and while idle: `cs_n` is all ones, the four strobes are high, `ale` is low, and `busy` and `done` are low.
- R2: A timed signal with offset o and width w is active on cycle clocks o+1 through o+w+1, where clock 0 is the first clock `busy` is high. Each value v therefore lasts v+1 clocks.
- R3: A cycle lasts T = cs_off+cs_wid+cs_rec+3 clocks with `busy` high. `done` is high for exactly the one clock after the last cycle clock, and `busy` is low in that clock.
- R4: Only bit `req_cs` of `cs_n` goes low, and only during the chip-select window. Bit i of `cs_n` belongs to index i.
- R5: One strobe at most is driven. It is chosen by {`req_write`,`req_mem`}: 00 selects `io_rd_n`, 01 `mem_rd_n`, 10 `io_wr_n`, 11 `mem_wr_n`. Reads use the rd timing and writes use the wr timing.
- R6: A strobe or latch-enable window that reaches past clock T-1 is cut off when the cycle ends.
- R7: `cfg_err` is set at acceptance when T ≤ o+w+2 for the selected strobe, or when T ≤ ale_off+ale_wid+2. It keeps that value until the next acceptance.
- R8: When `req_internal`=1 and `req_echo`=0, all pins stay inactive for the whole cycle, but `busy` and `done` still follow R3. In every other case the pins are driven.
- R9: A change to a timing input while `busy` is high has no effect on the cycle in progress.
- R10: `req_valid` is ignored while `busy` is high. It is accepted on any clock edge where `busy` is low, and `busy` rises right after that edge.
- R11: `ale` is active high in its own window. That window does not depend on the direction or the I/O-or-memory flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start request |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_mem | input | 1 | 1 = memory strobe, 0 = I/O strobe |
| req_cs | input | 3 | Chip-select index |
| req_internal | input | 1 | Target is an internal peripheral |
| req_echo | input | 1 | Echo mode enabled |
| cs_off | input | 8 | Chip-select offset |
| cs_wid | input | 8 | Chip-select width |
| cs_rec | input | 8 | Chip-select recovery |
| rd_off | input | 8 | Read strobe offset |
| rd_wid | input | 8 | Read strobe width |
| wr_off | input | 8 | Write strobe offset |
| wr_wid | input | 8 | Write strobe width |
| ale_off | input | 8 | Latch-enable offset |
| ale_wid | input | 8 | Latch-enable width |
| cs_n | output | 8 | Active-low chip selects |
| io_rd_n | output | 1 | I/O read strobe, active low |
| io_wr_n | output | 1 | I/O write strobe, active low |
| mem_rd_n | output | 1 | Memory read strobe, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| ale | output | 1 | Address latch enable, active high |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-clock end-of-cycle pulse |
| cfg_err | output | 1 | Timing inconsistency of the last accepted cycle |

## Verification
The all-zero settings give the shortest cycle. All-255 settings give the longest. Mixed offsets put the strobe, latch and chip-select windows apart, which shows that each group uses its own timing. Strobe settings that end exactly at, or past, the cycle end show the difference between a flagged but complete pulse and a truncated one. All four direction and space combinations, every chip-select index, and internal cycles with and without echo are run. Timing inputs are changed in the middle of a cycle, and requests are made while busy, to show that neither affects the current cycle.

// File: rtl/bct_pkg.sv
package bct_pkg;
    // Strobe selection code formed from {write, mem}
    typedef enum logic [1:0] {
        STB_IO_RD  = 2'b00,
        STB_MEM_RD = 2'b01,
        STB_IO_WR  = 2'b10,
        STB_MEM_WR = 2'b11
    } stb_sel_e;

    // Window slots in the timing array
    localparam int WIN_CS  = 0;
    localparam int WIN_STB = 1;
    localparam int WIN_ALE = 2;
    localparam int WIN_NUM = 3;
endpackage

// File: rtl/bct_window.sv
// Decides whether a cycle clock falls inside an offset/width window.
module bct_window #(
    parameter int TW = 8,
    parameter int CW = TW + 2
) (
    input  logic [CW-1:0] cnt,
    input  logic [TW-1:0] off,
    input  logic [TW-1:0] wid,
    output logic          hit
);
    logic [CW-1:0] first_clk;
    logic [CW-1:0] last_clk;

    always_comb begin
        first_clk = CW'(off) + CW'(1);
        last_clk  = CW'(off) + CW'(wid) + CW'(1);
        hit       = (cnt >= first_clk) && (cnt <= last_clk);
    end
endmodule

// File: rtl/bct_cfg_check.sv
// Works out the cycle length and checks it against the strobe and latch spans.
module bct_cfg_check #(
    parameter int TW = 8,
    parameter int CW = TW + 2
) (
    input  logic [TW-1:0] cs_off,
    input  logic [TW-1:0] cs_wid,
    input  logic [TW-1:0] cs_rec,
    input  logic [TW-1:0] stb_off,
    input  logic [TW-1:0] stb_wid,
    input  logic [TW-1:0] ale_off,
    input  logic [TW-1:0] ale_wid,
    output logic [CW-1:0] last_clk,
    output logic          err
);
    logic [CW-1:0] cs_total;
    logic [CW-1:0] stb_total;
    logic [CW-1:0] ale_total;

    always_comb begin
        cs_total  = CW'(cs_off) + CW'(cs_wid) + CW'(cs_rec) + CW'(3);
        stb_total = CW'(stb_off) + CW'(stb_wid) + CW'(2);
        ale_total = CW'(ale_off) + CW'(ale_wid) + CW'(2);
        last_clk  = cs_total - CW'(1);
        err       = (cs_total <= stb_total) || (cs_total <= ale_total);
    end
endmodule

// File: rtl/bus_cycle_timer.sv
module bus_cycle_timer
    import bct_pkg::*;
#(
    parameter int TIME_W = 8,
    parameter int CS_NUM = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic                      req_write,
    input  logic                      req_mem,
    input  logic [$clog2(CS_NUM)-1:0] req_cs,
    input  logic                      req_internal,
    input  logic                      req_echo,
    input  logic [TIME_W-1:0]         cs_off,
    input  logic [TIME_W-1:0]         cs_wid,
    input  logic [TIME_W-1:0]         cs_rec,
    input  logic [TIME_W-1:0]         rd_off,
    input  logic [TIME_W-1:0]         rd_wid,
    input  logic [TIME_W-1:0]         wr_off,
    input  logic [TIME_W-1:0]         wr_wid,
    input  logic [TIME_W-1:0]         ale_off,
    input  logic [TIME_W-1:0]         ale_wid,
    output logic [CS_NUM-1:0]         cs_n,
    output logic                      io_rd_n,
    output logic                      io_wr_n,
    output logic                      mem_rd_n,
    output logic                      mem_wr_n,
    output logic                      ale,
    output logic                      busy,
    output logic                      done,
    output logic                      cfg_err
);
    localparam int CW    = TIME_W + 2;
    localparam int IDX_W = $clog2(CS_NUM);

    typedef struct packed {
        logic              active;
        logic [CW-1:0]     cnt;
        logic [CW-1:0]     last;
        logic [TIME_W-1:0] cso;
        logic [TIME_W-1:0] csw;
        logic [TIME_W-1:0] sto;
        logic [TIME_W-1:0] stw;
        logic [TIME_W-1:0] alo;
        logic [TIME_W-1:0] alw;
        logic              drive;
        stb_sel_e          sel;
        logic [IDX_W-1:0]  idx;
        logic              done;
        logic              err;
    } core_t;

    typedef struct packed {
        logic [CS_NUM-1:0] cs_n;
        logic              io_rd_n;
        logic              io_wr_n;
        logic              mem_rd_n;
        logic              mem_wr_n;
        logic              ale;
    } pins_t;

    core_t core_d, core_q;
    pins_t pins_d, pins_q;

    logic              accept;
    logic [TIME_W-1:0] sel_off;
    logic [TIME_W-1:0] sel_wid;
    logic [CW-1:0]     chk_last;
    logic              chk_err;

    logic [TIME_W-1:0] win_off [WIN_NUM];
    logic [TIME_W-1:0] win_wid [WIN_NUM];
    logic [WIN_NUM-1:0] win_hit;

    assign accept  = req_valid && !core_q.active;
    assign sel_off = req_write ? wr_off : rd_off;
    assign sel_wid = req_write ? wr_wid : rd_wid;

    bct_cfg_check #(.TW(TIME_W), .CW(CW)) u_cfg_check (
        .cs_off   (cs_off),
        .cs_wid   (cs_wid),
        .cs_rec   (cs_rec),
        .stb_off  (sel_off),
        .stb_wid  (sel_wid),
        .ale_off  (ale_off),
        .ale_wid  (ale_wid),
        .last_clk (chk_last),
        .err      (chk_err)
    );

    // Sequencing: capture on accept, count through the cycle, pulse done at the end
    always_comb begin
        core_d      = core_q;
        core_d.done = 1'b0;
        if (accept) begin
            core_d.active = 1'b1;
            core_d.cnt    = '0;
            core_d.last   = chk_last;
            core_d.cso    = cs_off;
            core_d.csw    = cs_wid;
            core_d.sto    = sel_off;
            core_d.stw    = sel_wid;
            core_d.alo    = ale_off;
            core_d.alw    = ale_wid;
            core_d.drive  = !req_internal || req_echo;
            core_d.sel    = stb_sel_e'({req_write, req_mem});
            core_d.idx    = req_cs;
            core_d.err    = chk_err;
        end else if (core_q.active) begin
            if (core_q.cnt == core_q.last) begin
                core_d.active = 1'b0;
                core_d.cnt    = '0;
                core_d.done   = 1'b1;
            end else begin
                core_d.cnt = core_q.cnt + CW'(1);
            end
        end
    end

    always_comb begin
        win_off[WIN_CS]  = core_d.cso;
        win_wid[WIN_CS]  = core_d.csw;
        win_off[WIN_STB] = core_d.sto;
        win_wid[WIN_STB] = core_d.stw;
        win_off[WIN_ALE] = core_d.alo;
        win_wid[WIN_ALE] = core_d.alw;
    end

    for (genvar g = 0; g < WIN_NUM; g++) begin : g_win
        bct_window #(.TW(TIME_W), .CW(CW)) u_window (
            .cnt (core_d.cnt),
            .off (win_off[g]),
            .wid (win_wid[g]),
            .hit (win_hit[g])
        );
    end

    // Pin values for the next clock, from next-state count and windows
    always_comb begin
        logic drv;
        drv             = core_d.active && core_d.drive;
        pins_d.cs_n     = '1;
        pins_d.io_rd_n  = 1'b1;
        pins_d.io_wr_n  = 1'b1;
        pins_d.mem_rd_n = 1'b1;
        pins_d.mem_wr_n = 1'b1;
        pins_d.ale      = drv && win_hit[WIN_ALE];
        if (drv && win_hit[WIN_CS]) begin
            pins_d.cs_n[core_d.idx] = 1'b0;
        end
        if (drv && win_hit[WIN_STB]) begin
            case (core_d.sel)
                STB_IO_RD:  pins_d.io_rd_n  = 1'b0;
                STB_MEM_RD: pins_d.mem_rd_n = 1'b0;
                STB_IO_WR:  pins_d.io_wr_n  = 1'b0;
                default:    pins_d.mem_wr_n = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q          <= '0;
            pins_q.cs_n     <= '1;
            pins_q.io_rd_n  <= 1'b1;
            pins_q.io_wr_n  <= 1'b1;
            pins_q.mem_rd_n <= 1'b1;
            pins_q.mem_wr_n <= 1'b1;
            pins_q.ale      <= 1'b0;
        end else begin
            core_q <= core_d;
            pins_q <= pins_d;
        end
    end

    assign cs_n     = pins_q.cs_n;
    assign io_rd_n  = pins_q.io_rd_n;
    assign io_wr_n  = pins_q.io_wr_n;
    assign mem_rd_n = pins_q.mem_rd_n;
    assign mem_wr_n = pins_q.mem_wr_n;
    assign ale      = pins_q.ale;
    assign busy     = core_q.active;
    assign done     = core_q.done;
    assign cfg_err  = core_q.err;
endmodule

// File: rtl/bus_cycle_timer_chk.sv
module bus_cycle_timer_chk #(
    parameter int CS_NUM = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CS_NUM-1:0] cs_n,
    input logic              io_rd_n,
    input logic              io_wr_n,
    input logic              mem_rd_n,
    input logic              mem_wr_n,
    input logic              ale,
    input logic              busy,
    input logic              done,
    input logic              cfg_err
);
    // R1: pins quiet whenever no cycle runs
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (&cs_n && io_rd_n && io_wr_n && mem_rd_n && mem_wr_n && !ale));

    // R4: never more than one chip select low
    a_r4_single_cs: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    // R5: never more than one strobe low
    a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~io_rd_n, ~io_wr_n, ~mem_rd_n, ~mem_wr_n}) <= 1);

    // R3: done lasts one clock
    a_r3_done_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3: the end of busy comes with done
    a_r3_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R3: done never overlaps busy
    a_r3_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R7: the flag stays put during a running cycle
    a_r7_err_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cfg_err));
endmodule

bind bus_cycle_timer bus_cycle_timer_chk #(.CS_NUM(CS_NUM)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .io_rd_n  (io_rd_n),
    .io_wr_n  (io_wr_n),
    .mem_rd_n (mem_rd_n),
    .mem_wr_n (mem_wr_n),
    .ale      (ale),
    .busy     (busy),
    .done     (done),
    .cfg_err  (cfg_err)
);

// File: tb/bus_cycle_timer_bench.sv
`timescale 1ns/1ps
module bus_cycle_timer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0, req_write = 1'b0, req_mem = 1'b0;
    logic [2:0] req_cs = '0;
    logic       req_internal = 1'b0, req_echo = 1'b0;
    logic [7:0] cs_off = '0, cs_wid = '0, cs_rec = '0;
    logic [7:0] rd_off = '0, rd_wid = '0, wr_off = '0, wr_wid = '0;
    logic [7:0] ale_off = '0, ale_wid = '0;
    logic [7:0] cs_n;
    logic       io_rd_n, io_wr_n, mem_rd_n, mem_wr_n, ale, busy, done, cfg_err;

    always #2.5 clk = ~clk;

    bus_cycle_timer u_bus_cycle_timer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_mem(req_mem), .req_cs(req_cs), .req_internal(req_internal),
        .req_echo(req_echo), .cs_off(cs_off), .cs_wid(cs_wid), .cs_rec(cs_rec),
        .rd_off(rd_off), .rd_wid(rd_wid), .wr_off(wr_off), .wr_wid(wr_wid),
        .ale_off(ale_off), .ale_wid(ale_wid), .cs_n(cs_n), .io_rd_n(io_rd_n),
        .io_wr_n(io_wr_n), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .ale(ale),
        .busy(busy), .done(done), .cfg_err(cfg_err)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int n_clk = 0;

    // Behavioural reference: one integer clock counter per cycle
    int m_act = 0, m_t = 0, m_len = 0, m_done = 0, m_err = 0;
    int m_cso = 0, m_csw = 0, m_so = 0, m_sw = 0, m_ao = 0, m_aw = 0;
    int m_drv = 0, m_wr = 0, m_mem = 0, m_idx = 0;

    function automatic int in_win(int t, int o, int w);
        return (t >= o + 1 && t <= o + w + 1) ? 1 : 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_act = 0; m_t = 0; m_done = 0; m_err = 0;
        end else begin
            m_done = 0;
            if (m_act == 0 && req_valid) begin
                m_act = 1; m_t = 0;
                m_cso = cs_off; m_csw = cs_wid;
                m_len = int'(cs_off) + int'(cs_wid) + int'(cs_rec) + 3;
                m_so  = req_write ? wr_off : rd_off;
                m_sw  = req_write ? wr_wid : rd_wid;
                m_ao  = ale_off; m_aw = ale_wid;
                m_drv = (!req_internal || req_echo) ? 1 : 0;
                m_wr  = req_write; m_mem = req_mem; m_idx = req_cs;
                m_err = (m_len <= m_so + m_sw + 2 || m_len <= m_ao + m_aw + 2) ? 1 : 0;
            end else if (m_act != 0) begin
                if (m_t == m_len - 1) begin
                    m_act = 0; m_t = 0; m_done = 1;
                end else begin
                    m_t++;
                end
            end
        end
    end

    task automatic check(string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at clk %0d: actual %0h expected %0h", what, n_clk, act, exp);
        end
    endtask

    // Compare every clock, half a period after the edge
    always @(negedge clk) begin
        int on, stb;
        logic [7:0] e_cs;
        n_clk++;
        on   = m_act & m_drv;
        e_cs = 8'hFF;
        if (on != 0 && in_win(m_t, m_cso, m_csw) != 0) e_cs[m_idx] = 1'b0;
        stb  = on & in_win(m_t, m_so, m_sw);
        check("R2/R4 cs_n", cs_n, e_cs);
        check("R5/R6 io_rd_n",  io_rd_n,  (stb != 0 && m_wr == 0 && m_mem == 0) ? 0 : 1);
        check("R5/R6 mem_rd_n", mem_rd_n, (stb != 0 && m_wr == 0 && m_mem == 1) ? 0 : 1);
        check("R5/R6 io_wr_n",  io_wr_n,  (stb != 0 && m_wr == 1 && m_mem == 0) ? 0 : 1);
        check("R5/R6 mem_wr_n", mem_wr_n, (stb != 0 && m_wr == 1 && m_mem == 1) ? 0 : 1);
        check("R11 ale", ale, on & in_win(m_t, m_ao, m_aw));
        check("R3/R10 busy", busy, m_act);
        check("R3 done", done, m_done);
        check("R7 cfg_err", cfg_err, m_err);
    end

    task automatic set_t(int co, int cw, int cr, int ro, int rw, int wo, int ww, int ao, int aw);
        cs_off = 8'(co); cs_wid = 8'(cw); cs_rec = 8'(cr);
        rd_off = 8'(ro); rd_wid = 8'(rw); wr_off = 8'(wo); wr_wid = 8'(ww);
        ale_off = 8'(ao); ale_wid = 8'(aw);
    endtask

    task automatic start(bit wr, bit mem, int idx, bit intl, bit echo);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_mem = mem;
        req_cs = 3'(idx); req_internal = intl; req_echo = echo;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic finish_cycle();
        for (int i = 0; i < 1000 && !done; i++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run(bit wr, bit mem, int idx, bit intl, bit echo);
        start(wr, mem, idx, intl, echo);
        finish_cycle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        check("R1 reset cs_n", cs_n, 8'hFF);
        check("R1 reset strobes", {io_rd_n, io_wr_n, mem_rd_n, mem_wr_n}, 4'hF);
        check("R1 reset ale/busy/done", {ale, busy, done}, 3'b000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2/R3: shortest cycle, all zero
        set_t(0, 0, 0, 0, 0, 0, 0, 0, 0);
        run(0, 0, 0, 0, 0);
        // R2/R11: distinct windows for every group
        set_t(2, 5, 3, 3, 2, 1, 4, 0, 1);
        run(0, 0, 3, 0, 0);
        run(1, 1, 5, 0, 0);
        // R5/R4: every direction and space, every index
        for (int k = 0; k < 8; k++) run(k[0], k[1], k, 0, 0);
        // R6/R7: strobe past the end is cut, flag set
        set_t(1, 1, 0, 2, 6, 0, 0, 0, 0);
        run(0, 1, 2, 0, 0);
        // R7: strobe ends exactly at the cycle end, flagged but whole
        set_t(1, 1, 1, 1, 3, 0, 0, 0, 0);
        run(0, 0, 1, 0, 0);
        // R7: latch-enable overrun alone sets the flag, then a clean cycle clears it
        set_t(1, 1, 1, 0, 0, 0, 0, 3, 4);
        run(1, 0, 4, 0, 0);
        set_t(3, 3, 3, 1, 1, 1, 1, 1, 1);
        run(1, 0, 4, 0, 0);
        // R8: internal target without echo, then with echo, then external with echo
        run(0, 0, 6, 1, 0);
        run(1, 1, 6, 1, 1);
        run(0, 1, 7, 0, 1);
        // R9: timing inputs changed while busy
        start(0, 0, 2, 0, 0);
        repeat (3) @(negedge clk);
        set_t(9, 9, 9, 9, 9, 9, 9, 9, 9);
        finish_cycle();
        // R10: requests held during a cycle are ignored
        set_t(4, 6, 4, 2, 3, 2, 3, 1, 1);
        start(0, 0, 1, 0, 0);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_cs = 3'd7;
        repeat (3) @(negedge clk);
        req_valid = 1'b0;
        finish_cycle();
        // R10: back-to-back request accepted in the done clock
        set_t(0, 1, 0, 0, 0, 0, 1, 0, 0);
        start(1, 0, 3, 0, 0);
        for (int i = 0; i < 20 && !done; i++) @(negedge clk);
        req_valid = 1'b1; req_cs = 3'd5;
        @(negedge clk);
        req_valid = 1'b0;
        finish_cycle();
        // R3: longest cycle
        set_t(255, 255, 255, 255, 255, 255, 255, 255, 255);
        run(0, 1, 0, 0, 0);
        repeat (4) @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        while (n_clk < 150000) @(negedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule